// File: doc/BRIEF.md
# Open-Drain Nibble Port with Bit Operations

This block is a 4-bit bidirectional port of the kind a small microcontroller core uses for general-purpose pins. It holds an output latch. Each latch bit controls one open-drain pin. A latch bit of 0 turns on that pin's pull-down, so the pin is driven low. A latch bit of 1 releases the pin, so an external pull-up or another device sets its level. The block gives one drive-low enable per pin and takes in the level actually present on each pin.

The core accesses the port through single-cycle strobes:
- a whole-nibble load of the latch;
- a set or a clear of one latch bit, chosen by a 2-bit index.

Reads do not return the latch contents. The nibble read and the single-bit test both use the resolved pin levels. The bit test has a polarity input, so one output serves both a branch-when-high and a branch-when-low decision.

The port's output level during reset comes from a single option input that covers all four pins. While reset is held, the option value is copied into every latch bit on each clock. The port therefore comes out of reset either driving all pins low or releasing all of them. A chip with several such ports gives each instance its own option input.

Top module: `nib_port`

## Requirements
- R1: While rst_n is low, after a rising clock edge, every latch bit equals rst_level_i. With rst_level_i = 1, drive_low_o is 4'b0000. With rst_level_i = 0, drive_low_o is 4'b1111.
- R2: The reset option is sampled on every clock while rst_n is low. A change of rst_level_i during reset appears on drive_low_o after the next rising edge.
- R3: When wr_en_i is high on a rising edge with rst_n high, the latch takes wr_data_i, so drive_low_o becomes ~wr_data_i.
- R4: When set_en_i is the highest-priority strobe, latch bit bit_idx_i becomes 1. That pin is released (drive_low_o bit 0) and the other three bits keep their values.
- R5: When clr_en_i is the only active strobe, latch bit bit_idx_i becomes 0. That pin is driven low (drive_low_o bit 1) and the other three bits keep their values.
- R6: When several strobes are active together, only one acts. The nibble write beats the bit set, and the bit set beats the bit clear.
- R7: On a rising edge with no strobe active and rst_n high, the latch keeps its value.
- R8: rd_data_o shows the resolved pin levels pin_i in the same cycle, not the latch. A released pin that is pulled low externally reads 0.
- R9: bit_hit_o equals pin_i[bit_idx_i] when br_on_low_i is 0, and its inverse when br_on_low_i is 1. It is combinational in the current cycle.
- R10: Strobes active while rst_n is low have no effect on the latch. Only the reset option is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_level_i | input | 1 | Reset option: 1 releases all pins, 0 drives all pins low |
| wr_en_i | input | 1 | Nibble write strobe |
| wr_data_i | input | 4 | Nibble write data |
| set_en_i | input | 1 | Single-bit set strobe |
| clr_en_i | input | 1 | Single-bit clear strobe |
| bit_idx_i | input | 2 | Bit index for set, clear and test |
| br_on_low_i | input | 1 | Test polarity: 0 hits on a high pin, 1 hits on a low pin |
| pin_i | input | 4 | Resolved pin levels |
| drive_low_o | output | 4 | Per-pin pull-down enable |
| rd_data_o | output | 4 | Nibble read of the pin levels |
| bit_hit_o | output | 1 | Branch condition for the selected bit |

## Verification
The only state in this block is the output latch. A wrong latch bit appears on drive_low_o one edge after the operation that caused it. It then also pulls the resolved pin low, or fails to, so rd_data_o and bit_hit_o show the same error in that cycle. Because of this, every check samples just after the edge that follows its strobe.

A corrupted neighbour bit after a set or clear, or a wrong strobe priority, is found in the very next cycle. The read path is checked separately by pulling released pins low from outside. That way a read that wrongly returns the latch cannot pass.

// File: rtl/nib_port_pkg.sv
package nib_port_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } port_op_e;

endpackage

// File: rtl/nib_port_opsel.sv
// Collapses the three strobes into one operation, priority write > set > clear.
module nib_port_opsel
    import nib_port_pkg::*;
(
    input  logic     wr_en_i,
    input  logic     set_en_i,
    input  logic     clr_en_i,
    output port_op_e op_o
);

    always_comb begin
        if (wr_en_i) begin
            op_o = OP_WR;
        end else if (set_en_i) begin
            op_o = OP_SET;
        end else if (clr_en_i) begin
            op_o = OP_CLR;
        end else begin
            op_o = OP_NONE;
        end
    end

endmodule

// File: rtl/nib_port_latch.sv
// Output latch: the next value is built in one struct, then registered.
module nib_port_latch
    import nib_port_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_level_i,
    input  port_op_e         op_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    output logic [WIDTH-1:0] lat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] lat;
    } lat_state_t;

    lat_state_t st_d;
    lat_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.lat = {WIDTH{rst_level_i}};
        end else begin
            case (op_i)
                OP_WR:   st_d.lat = wr_data_i;
                OP_SET:  st_d.lat[bit_idx_i] = 1'b1;
                OP_CLR:  st_d.lat[bit_idx_i] = 1'b0;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

endmodule

// File: rtl/nib_port_bitsel.sv
// Selects one resolved pin level and applies the branch polarity.
module nib_port_bitsel #(
    parameter int WIDTH = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] pin_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             br_on_low_i,
    output logic             hit_o
);

    logic [WIDTH-1:0] sel_onehot;
    logic             sel_level;

    for (genvar g = 0; g < WIDTH; g++) begin : g_sel
        assign sel_onehot[g] = (bit_idx_i == IDX_W'(g)) & pin_i[g];
    end

    assign sel_level = |sel_onehot;
    assign hit_o     = sel_level ^ br_on_low_i;

endmodule

// File: rtl/nib_port.sv
module nib_port
    import nib_port_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_level_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             set_en_i,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             br_on_low_i,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] drive_low_o,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             bit_hit_o
);

    port_op_e         op;
    logic [WIDTH-1:0] lat;

    nib_port_opsel u_opsel (
        .wr_en_i  (wr_en_i),
        .set_en_i (set_en_i),
        .clr_en_i (clr_en_i),
        .op_o     (op)
    );

    nib_port_latch #(.WIDTH(WIDTH)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_level_i (rst_level_i),
        .op_i        (op),
        .wr_data_i   (wr_data_i),
        .bit_idx_i   (bit_idx_i),
        .lat_o       (lat)
    );

    // Open drain: a latch 0 turns the pull-down on, a latch 1 releases the pin.
    for (genvar g = 0; g < WIDTH; g++) begin : g_drv
        assign drive_low_o[g] = ~lat[g];
    end

    assign rd_data_o = pin_i;

    nib_port_bitsel #(.WIDTH(WIDTH)) u_bitsel (
        .pin_i       (pin_i),
        .bit_idx_i   (bit_idx_i),
        .br_on_low_i (br_on_low_i),
        .hit_o       (bit_hit_o)
    );

endmodule

// File: rtl/nib_port_chk.sv
module nib_port_chk #(
    parameter int WIDTH = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [WIDTH-1:0] wr_data_i,
    input logic             set_en_i,
    input logic             clr_en_i,
    input logic [IDX_W-1:0] bit_idx_i,
    input logic [WIDTH-1:0] drive_low_o
);

    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (drive_low_o == ~$past(wr_data_i)));

    p_set_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && set_en_i) |=> (drive_low_o[$past(bit_idx_i)] == 1'b0));

    p_set_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && set_en_i) |=> ($countones(drive_low_o ^ $past(drive_low_o)) <= 1));

    p_clr_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !set_en_i && clr_en_i) |=> (drive_low_o[$past(bit_idx_i)] == 1'b1));

    p_clr_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !set_en_i && clr_en_i)
        |=> ($countones(drive_low_o ^ $past(drive_low_o)) <= 1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !set_en_i && !clr_en_i) |=> $stable(drive_low_o));

endmodule

bind nib_port nib_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .set_en_i    (set_en_i),
    .clr_en_i    (clr_en_i),
    .bit_idx_i   (bit_idx_i),
    .drive_low_o (drive_low_o)
);

// File: tb/nib_port_tb.sv
`timescale 1ns/1ps
module nib_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_level = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic       set_en = 1'b0;
    logic       clr_en = 1'b0;
    logic [1:0] bit_idx = 2'd0;
    logic       br_on_low = 1'b0;
    logic [3:0] ext_low = 4'h0;
    logic [3:0] pin;
    logic [3:0] drive_low;
    logic [3:0] rd_data;
    logic       bit_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Pin model: weak pull-up, overridden by the port's pull-down or an external low.
    assign pin = ~(drive_low | ext_low);

    nib_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_level_i (rst_level),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .set_en_i    (set_en),
        .clr_en_i    (clr_en),
        .bit_idx_i   (bit_idx),
        .br_on_low_i (br_on_low),
        .pin_i       (pin),
        .drive_low_o (drive_low),
        .rd_data_o   (rd_data),
        .bit_hit_o   (bit_hit)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        set_en = 1'b0;
        clr_en = 1'b0;
    endtask

    task automatic t_reset_levels();
        rst_n = 1'b0; rst_level = 1'b1;
        tick();
        check("R1 level1 drive", drive_low, 4'b0000);
        check("R1 level1 read", rd_data, 4'b1111);
        rst_level = 1'b0;
        tick();
        check("R1 level0 drive", drive_low, 4'b1111);
        check("R1 level0 read", rd_data, 4'b0000);
    endtask

    task automatic t_reset_resample();
        rst_level = 1'b0;
        tick();
        rst_level = 1'b1;
        tick();
        check("R2 resample", drive_low, 4'b0000);
    endtask

    task automatic t_reset_ignores_ops();
        rst_level = 1'b1;
        wr_en = 1'b1; wr_data = 4'b0000; clr_en = 1'b1; bit_idx = 2'd1;
        tick();
        check("R10 ops ignored in reset", drive_low, 4'b0000);
    endtask

    task automatic t_write();
        rst_n = 1'b1;
        wr_en = 1'b1; wr_data = 4'b1010;
        tick();
        check("R3 write 1010", drive_low, 4'b0101);
        check("R3 read after write", rd_data, 4'b1010);
        wr_en = 1'b1; wr_data = 4'b0110;
        tick();
        check("R3 write 0110", drive_low, 4'b1001);
    endtask

    task automatic t_set();
        set_en = 1'b1; bit_idx = 2'd0;
        tick();
        check("R4 set bit0", drive_low, 4'b1000);
        set_en = 1'b1; bit_idx = 2'd3;
        tick();
        check("R4 set bit3", drive_low, 4'b0000);
    endtask

    task automatic t_clear();
        clr_en = 1'b1; bit_idx = 2'd2;
        tick();
        check("R5 clear bit2", drive_low, 4'b0100);
        clr_en = 1'b1; bit_idx = 2'd0;
        tick();
        check("R5 clear bit0", drive_low, 4'b0101);
    endtask

    task automatic t_priority();
        wr_en = 1'b1; wr_data = 4'b0000; set_en = 1'b1; clr_en = 1'b1; bit_idx = 2'd1;
        tick();
        check("R6 write beats set/clear", drive_low, 4'b1111);
        set_en = 1'b1; clr_en = 1'b1; bit_idx = 2'd1;
        tick();
        check("R6 set beats clear", drive_low, 4'b1101);
    endtask

    task automatic t_hold();
        tick();
        tick();
        check("R7 hold", drive_low, 4'b1101);
    endtask

    task automatic t_read_ext();
        wr_en = 1'b1; wr_data = 4'b1111;
        tick();
        ext_low = 4'b0100;
        #1;
        check("R8 external low read", rd_data, 4'b1011);
        check("R8 latch unchanged", drive_low, 4'b0000);
    endtask

    task automatic t_bit_test();
        bit_idx = 2'd2; br_on_low = 1'b0;
        #1;
        check("R9 test low pin", {3'b000, bit_hit}, 4'b0000);
        br_on_low = 1'b1;
        #1;
        check("R9 inverted test", {3'b000, bit_hit}, 4'b0001);
        bit_idx = 2'd0; br_on_low = 1'b0;
        #1;
        check("R9 test high pin", {3'b000, bit_hit}, 4'b0001);
        ext_low = 4'b0000;
    endtask

    initial begin
        #1;
        t_reset_levels();
        t_reset_resample();
        t_reset_ignores_ops();
        t_write();
        t_set();
        t_clear();
        t_priority();
        t_hold();
        t_read_ext();
        t_bit_test();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule